// File: doc/BRIEF.md
# Glitch-Free Full/Half Rate Clock Selector

The block drives a set of output clocks that run either at the input clock frequency or at half of it. Two active-low controls pick the rate: a pin and a single configuration bit held in a small register, which is loaded through a one-bit write port clocked by the input clock. Either control held low selects half rate. Full rate needs both controls high. All output clocks follow the same selection.

A toggle flop on the input clock makes the half-rate clock. It runs all the time, so it is always ready and in phase. The combined request passes through a two-stage synchronizer. A selection flop on the falling input edge then updates the output multiplexer. It changes only at a falling edge where the divided clock is also low, so no high phase of either clock is cut short. A rate change lands within a small fixed number of input periods. The register bit resets to one, so the block starts at full rate.

Top module: `div2_mode_switch`

## Requirements
- R1: While reset is asserted, and after reset with the pin high and no write made, every output runs at the input frequency.
- R2: Half rate is selected when the pin is low, when the stored bit is 0, or both. Full rate is selected only when both are 1. A control change that leaves this combination unchanged produces no output pulse at the other rate.
- R3: At full rate, every output high and low phase lasts one half of the input period.
- R4: At half rate, every output high and low phase lasts one full input period.
- R5: After the combined request moves to half rate, the first complete half-rate pulse rises within 2 to 6 input periods. The delay is counted from the pin change, or from the rising edge that captures a register write.
- R6: After the combined request moves to full rate, the first complete full-rate pulse rises within 2 to 6 input periods, counted the same way as in R5.
- R7: The output never glitches. Every high or low phase, including those around a rate change, lasts either a half or a whole input period. The selection changes only when the divided clock is low.
- R8: The stored bit resets to 1. On a rising input edge with cfg_we_i high it takes cfg_wdata_i. With cfg_we_i low it keeps its value whatever cfg_wdata_i does.
- R9: All output clock bits are identical at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock; source of both rates |
| rst_ni | input | 1 | Asynchronous active-low reset |
| half_pin_ni | input | 1 | Active-low half-rate request pin, asynchronous |
| cfg_we_i | input | 1 | Write strobe for the rate configuration bit |
| cfg_wdata_i | input | 1 | Write data; 0 requests half rate, 1 allows full rate |
| clk_o | output | NUM_OUT | Selected output clocks, all identical |

## Verification
The hardest case to reach is the handover itself. The selection may land on either of two falling edges, depending on the phase of the divided clock. A bad switch would show up only as one shortened phase next to the change. The stimulus walks every single-control transition among the four pin and bit combinations, applying each from both the pin and the write port. Because request changes are placed on successive cycles, both divider phases come up at the handover. A monitor measures every output phase against the two nominal lengths. It also times the first full pulse at the new rate and counts any pulse at the wrong rate after a change that leaves the rate as it was.

// File: rtl/div2_pkg.sv
package div2_pkg;
  typedef enum logic {
    RATE_FULL = 1'b0,
    RATE_HALF = 1'b1
  } rate_e;
endpackage

// File: rtl/div2_cfg_reg.sv
module div2_cfg_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic wdata_i,
  output logic full_ok_o
);
  logic bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bit_q <= 1'b1;
    else if (we_i) bit_q <= wdata_i;
  end

  assign full_ok_o = bit_q;

  AST_CFG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (bit_q == $past(wdata_i))); // R8
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(bit_q)); // R8
endmodule

// File: rtl/div2_sync.sv
module div2_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) ff_q[0] <= 1'b0;
          else         ff_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) ff_q[s] <= 1'b0;
          else         ff_q[s] <= ff_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/div2_rate_mux.sv
module div2_rate_mux
  import div2_pkg::*;
#(
  parameter int NUM_OUT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               half_req_i,
  output logic [NUM_OUT-1:0] clk_o
);
  logic  div_q;
  rate_e sel_q;

  // free-running divider, always phase ready
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= 1'b0;
    else         div_q <= ~div_q;
  end

  // switch on falling input edge while divided clock is low: both sources low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= RATE_FULL;
    else if (!div_q) sel_q <= half_req_i ? RATE_HALF : RATE_FULL;
  end

  generate
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
      assign clk_o[g] = (sel_q == RATE_HALF) ? div_q : clk_i;
    end
  endgenerate

  AST_SEL_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_q) |-> !div_q); // R7
  AST_DIV_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (div_q != $past(div_q))); // R4
endmodule

// File: rtl/div2_mode_switch.sv
module div2_mode_switch #(
  parameter int NUM_OUT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               half_pin_ni,
  input  logic               cfg_we_i,
  input  logic               cfg_wdata_i,
  output logic [NUM_OUT-1:0] clk_o
);
  logic full_ok;
  logic half_req_raw;
  logic half_req_sync;

  div2_cfg_reg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .wdata_i   (cfg_wdata_i),
    .full_ok_o (full_ok)
  );

  // either active-low source selects half rate
  assign half_req_raw = ~half_pin_ni | ~full_ok;

  div2_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (half_req_raw),
    .q_o    (half_req_sync)
  );

  div2_rate_mux #(.NUM_OUT(NUM_OUT)) u_mux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .half_req_i (half_req_sync),
    .clk_o      (clk_o)
  );
endmodule

// File: tb/div2_mode_switch_test.sv
`timescale 1ns/1ps
module div2_mode_switch_test;
  localparam int      NUM_OUT = 4;
  localparam realtime TP      = 5.0;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic half_pin_ni = 1'b1;
  logic cfg_we_i = 1'b0;
  logic cfg_wdata_i = 1'b1;
  logic [NUM_OUT-1:0] clk_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  div2_mode_switch #(.NUM_OUT(NUM_OUT), .SYNC_STAGES(2)) uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .half_pin_ni (half_pin_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .clk_o       (clk_o)
  );

  always #(TP/2) clk_i = ~clk_i;

  function automatic bit near(realtime a, realtime b);
    return (a > b - 0.1) && (a < b + 0.1);
  endfunction

  // phase monitor
  realtime t_rise = 0.0, t_fall = 0.0, t_req = 1.0e12, t_first = 0.0;
  realtime last_high = 0.0;
  bit have_rise = 0, have_fall = 0, got_first = 0, want_half = 0;
  int other_cnt = 0;

  always @(posedge clk_o[0]) begin
    if (have_fall) begin
      checks++;
      if (!near($realtime - t_fall, TP/2) && !near($realtime - t_fall, TP)) begin
        errors++;
        $display("FAIL R7 low phase %0.3f expected %0.3f or %0.3f", $realtime - t_fall, TP/2, TP);
      end
    end
    t_rise = $realtime;
    have_rise = 1;
  end

  always @(negedge clk_o[0]) begin
    if (have_rise) begin
      last_high = $realtime - t_rise;
      checks++;
      if (!near(last_high, TP/2) && !near(last_high, TP)) begin
        errors++;
        $display("FAIL R7 high phase %0.3f expected %0.3f or %0.3f", last_high, TP/2, TP);
      end
      if (t_rise > t_req) begin
        if (near(last_high, want_half ? TP : TP/2)) begin
          if (!got_first) begin got_first = 1; t_first = t_rise; end
        end else other_cnt++;
      end
    end
    t_fall = $realtime;
    have_fall = 1;
  end

  task automatic check_bit(string tag, bit ok, string what, realtime act, realtime exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0.3f expected %0.3f", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs_equal();
    for (int k = 0; k < 8; k++) begin
      #(TP*0.35);
      check_bit("R9", clk_o == {NUM_OUT{clk_o[0]}}, "outputs differ bits",
                real'(clk_o), real'({NUM_OUT{clk_o[0]}}));
    end
  endtask

  task automatic arm(bit half);
    want_half = half;
    got_first = 0;
    other_cnt = 0;
    t_req = 1.0e12;
  endtask

  task automatic set_pin(bit v);
    @(posedge clk_i);
    #1 half_pin_ni = v;
    t_req = $realtime;
  endtask

  task automatic write_cfg(bit v);
    @(posedge clk_i);
    #1 cfg_we_i = 1'b1; cfg_wdata_i = v;
    @(posedge clk_i);
    t_req = $realtime;
    #1 cfg_we_i = 1'b0; cfg_wdata_i = ~v;
  endtask

  // one single-control transition; pin/reg are the new levels
  task automatic step(bit use_pin, bit v, bit pin, bit rg, bit was_half);
    bit half;
    int n;
    half = !pin || !rg;
    arm(half);
    if (use_pin) set_pin(v); else write_cfg(v);
    repeat (20) @(posedge clk_i);
    #(TP*0.25);
    if (half != was_half) begin
      n = $rtoi((t_first - t_req) / TP + 0.5);
      check_bit(half ? "R5" : "R6", got_first, "new rate pulse seen", real'(got_first), 1.0);
      check_bit(half ? "R5" : "R6", got_first && n >= 2 && n <= 6, "switch latency periods",
                real'(n), 4.0);
    end else begin
      check_bit("R2", other_cnt == 0, "pulses at other rate", real'(other_cnt), 0.0);
    end
    if (half)
      check_bit("R4", near(last_high, TP), "half rate high phase", last_high, TP);
    else
      check_bit("R3", near(last_high, TP/2), "full rate high phase", last_high, TP/2);
    check_bit("R2", got_first, "rate matches pin/bit combination", real'(got_first), 1.0);
    check_outputs_equal();
  endtask

  initial begin
    #(TP * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // reset: output follows the input clock
    arm(1'b0);
    t_req = 0.0;
    repeat (6) @(posedge clk_i);
    #(TP*0.25);
    check_bit("R1", got_first && other_cnt == 0, "full rate during reset",
              real'(other_cnt), 0.0);
    @(posedge clk_i);
    #1 rst_ni = 1'b1;
    arm(1'b0);
    t_req = $realtime;
    repeat (20) @(posedge clk_i);
    #(TP*0.25);
    check_bit("R1", got_first && other_cnt == 0, "full rate after reset",
              real'(other_cnt), 0.0);
    check_bit("R1", near(last_high, TP/2), "high phase after reset", last_high, TP/2);
    check_outputs_equal();

    // R8: strobe low, data toggling: no effect
    arm(1'b0);
    t_req = $realtime;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk_i);
      #1 cfg_wdata_i = k[0];
    end
    repeat (10) @(posedge clk_i);
    #(TP*0.25);
    check_bit("R8", other_cnt == 0 && got_first, "write without strobe changed rate",
              real'(other_cnt), 0.0);

    // all 8 single-control transitions over (pin, bit)
    step(1, 0, 0, 1, 0); // 11 -> 01 half
    step(0, 0, 0, 0, 1); // 01 -> 00 stays half
    step(0, 1, 0, 1, 1); // 00 -> 01 stays half
    step(1, 1, 1, 1, 1); // 01 -> 11 full
    step(0, 0, 1, 0, 0); // 11 -> 10 half
    step(1, 0, 0, 0, 1); // 10 -> 00 stays half
    step(1, 1, 1, 0, 1); // 00 -> 10 stays half
    step(0, 1, 1, 1, 1); // 10 -> 11 full

    // repeat pin toggling with shifted timing to hit both divider phases
    for (int d = 0; d < 4; d++) begin
      repeat (d) @(posedge clk_i);
      step(1, 0, 0, 1, 0);
      repeat (d + 1) @(posedge clk_i);
      step(1, 1, 1, 1, 1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule